// File: doc/BRIEF.md
# Append-Only Configuration Slot Manager

This block keeps track of a small write-once configuration store. The store has a fixed number of record slots, eight by default, and every record is tagged with a 3-bit identifier. A save request appends one record carrying the given identifier to the next free slot. All identifiers draw on the same slot budget. A record is never overwritten. A save made when every slot is already used is refused.

A load request names an identifier, which in the system is the value a power-up strap decoder selects. The block then looks for the most recently written record with that identifier. It starts at the newest slot and checks one slot per clock, moving toward the oldest. It reports the slot index of the first match, or flags that no record matched. While a lookup is running, `busy` is high and all new requests are ignored. The record RAM is modelled inside the block. Strap measurement and real nonvolatile programming belong elsewhere.

Top module: `cfgslot_mgr`

## Requirements
- R1: After reset, the outputs `busy`, `store_full`, `full_err`, `not_found`, `slot_valid` and `load_done` are all 0, and the store holds no records.
- R2: An accepted save writes its identifier into slot k, where k is the number of records stored before it. `store_full` goes high once all NUM_SLOTS slots are used.
- R3: A save accepted while the store is full is rejected. `full_err` reads 1 from the next cycle, and the stored records and their count stay unchanged. `full_err` returns to 0 when the next request is accepted.
- R4: A load that finds a match sets `slot_idx` to the highest slot index holding that identifier and sets `slot_valid` to 1. It clears `not_found` and pulses `load_done` high for one cycle.
- R5: A lookup checks one slot per cycle, from slot count-1 down toward slot 0. On a hit at slot m, `busy` stays high for exactly count-m cycles after the accept edge, and `load_done` is high in the cycle after `busy` falls.
- R6: A load with no matching record keeps `busy` high for exactly count cycles, which is none when the store is empty. It then sets `not_found` to 1 and pulses `load_done`. `slot_idx` and `slot_valid` stay unchanged.
- R7: While `busy` is high, `save_req` and `load_req` are ignored. No record is appended and the running lookup is not restarted.
- R8: When the block is idle and `save_req` and `load_req` are high in the same cycle, the save is accepted and the load is dropped.
- R9: All identifiers share the slot budget. Eight saves of the same identifier fill the store, and so do eight saves of eight different identifiers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| save_req | input | 1 | Request to append a record |
| save_id | input | ID_W | Identifier for the record to append |
| load_req | input | 1 | Request to look up the newest record for an identifier |
| load_id | input | ID_W | Identifier to look up (strap selection) |
| busy | output | 1 | A lookup is in progress; requests are ignored |
| store_full | output | 1 | All slots are used |
| full_err | output | 1 | The last accepted save was refused because the store was full |
| not_found | output | 1 | The last lookup found no match |
| load_done | output | 1 | One-cycle pulse when a lookup ends |
| slot_valid | output | 1 | `slot_idx` holds the result of a successful lookup |
| slot_idx | output | $clog2(NUM_SLOTS) | Slot of the newest matching record |

## Verification
The store is filled to every length from zero to eight with five identifier patterns: one identifier repeated, ascending, descending, a strided permutation, and two identifiers alternating. After each fill, all eight identifiers are looked up. The repeated and alternating patterns show whether the newest record wins over older duplicates. The permutations check each slot position as a hit location, and the partial fills show whether the scan starts at the true fill level rather than at the top slot. Counting `busy` cycles makes the newest-to-oldest order visible at the ports. Separate runs try a save on a full store, requests made during a running scan, and a save and load arriving together.

// File: rtl/cfgslot_pkg.sv
package cfgslot_pkg;
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;
endpackage

// File: rtl/cfgslot_store.sv
module cfgslot_store #(
  parameter int NUM_SLOTS = 8,
  parameter int ID_W      = 3,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ID_W-1:0]  wr_id,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ID_W-1:0]  rd_id,
  output logic [CNT_W-1:0] fill,
  output logic             full
);

  logic [ID_W-1:0]  rec_q [NUM_SLOTS];
  logic [CNT_W-1:0] fill_q, fill_d;

  // one write strobe per slot, selected by the fill level
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en && (fill_q == CNT_W'(g));
    always_ff @(posedge clk) begin
      if (slot_we) rec_q[g] <= wr_id;
    end
  end

  always_comb begin
    fill_d = fill_q;
    if (wr_en && !full) fill_d = fill_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_q <= '0;
    else        fill_q <= fill_d;
  end

  assign full  = (fill_q == CNT_W'(NUM_SLOTS));
  assign fill  = fill_q;
  assign rd_id = rec_q[rd_idx];

  // R2
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CNT_W'(NUM_SLOTS));

  // R3
  no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);

endmodule

// File: rtl/cfgslot_scan.sv
module cfgslot_scan
  import cfgslot_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int ID_W      = 3,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ID_W-1:0]  start_id,
  input  logic [CNT_W-1:0] fill,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [ID_W-1:0]  rd_id,
  output logic             busy,
  output logic             hit,
  output logic             miss,
  output logic [IDX_W-1:0] hit_idx
);

  scan_state_e      state_q, state_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [ID_W-1:0]  key_q, key_d;
  logic             running, match, at_oldest;

  assign running   = (state_q == SCAN_RUN);
  assign match     = (rd_id == key_q);
  assign at_oldest = (ptr_q == '0);

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    key_d   = key_q;
    hit     = 1'b0;
    miss    = 1'b0;
    if (running) begin
      if (match) begin
        hit     = 1'b1;
        state_d = SCAN_IDLE;
      end else if (at_oldest) begin
        miss    = 1'b1;
        state_d = SCAN_IDLE;
      end else begin
        ptr_d = ptr_q - IDX_W'(1);
      end
    end else if (start) begin
      key_d = start_id;
      if (fill == '0) begin
        miss = 1'b1;
      end else begin
        ptr_d   = IDX_W'(fill - CNT_W'(1));
        state_d = SCAN_RUN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
      ptr_q   <= '0;
      key_q   <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      key_q   <= key_d;
    end
  end

  assign rd_idx  = ptr_q;
  assign hit_idx = ptr_q;
  assign busy    = running;

  // R5
  scan_step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !hit && !miss) |=> (running && ptr_q == $past(ptr_q) - IDX_W'(1)));

  // R5
  scan_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (CNT_W'(ptr_q) < fill));

  // R4
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && miss));

endmodule

// File: rtl/cfgslot_mgr.sv
module cfgslot_mgr #(
  parameter int NUM_SLOTS = 8,
  parameter int ID_W      = 3,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             save_req,
  input  logic [ID_W-1:0]  save_id,
  input  logic             load_req,
  input  logic [ID_W-1:0]  load_id,
  output logic             busy,
  output logic             store_full,
  output logic             full_err,
  output logic             not_found,
  output logic             load_done,
  output logic             slot_valid,
  output logic [IDX_W-1:0] slot_idx
);

  logic             save_go, load_go, wr_en, save_rej;
  logic             hit, miss, scan_busy, full;
  logic [IDX_W-1:0] rd_idx, hit_idx;
  logic [ID_W-1:0]  rd_id;
  logic [CNT_W-1:0] fill;

  logic             full_err_q, full_err_d;
  logic             nf_q, nf_d;
  logic             done_q, done_d;
  logic             valid_q, valid_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  // request acceptance: idle only, save wins over load
  assign save_go  = save_req && !scan_busy;
  assign load_go  = load_req && !scan_busy && !save_req;
  assign wr_en    = save_go && !full;
  assign save_rej = save_go && full;

  cfgslot_store #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_id  (save_id),
    .rd_idx (rd_idx),
    .rd_id  (rd_id),
    .fill   (fill),
    .full   (full)
  );

  cfgslot_scan #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (load_go),
    .start_id (load_id),
    .fill     (fill),
    .rd_idx   (rd_idx),
    .rd_id    (rd_id),
    .busy     (scan_busy),
    .hit      (hit),
    .miss     (miss),
    .hit_idx  (hit_idx)
  );

  always_comb begin
    full_err_d = full_err_q;
    if (save_rej)               full_err_d = 1'b1;
    else if (save_go || load_go) full_err_d = 1'b0;

    nf_d = nf_q;
    if (miss)         nf_d = 1'b1;
    else if (hit)     nf_d = 1'b0;
    else if (load_go) nf_d = 1'b0;

    idx_d   = hit ? hit_idx : idx_q;
    valid_d = hit ? 1'b1 : valid_q;
    done_d  = hit || miss;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_err_q <= 1'b0;
      nf_q       <= 1'b0;
      done_q     <= 1'b0;
      valid_q    <= 1'b0;
      idx_q      <= '0;
    end else begin
      full_err_q <= full_err_d;
      nf_q       <= nf_d;
      done_q     <= done_d;
      valid_q    <= valid_d;
      idx_q      <= idx_d;
    end
  end

  assign busy       = scan_busy;
  assign store_full = full;
  assign full_err   = full_err_q;
  assign not_found  = nf_q;
  assign load_done  = done_q;
  assign slot_valid = valid_q;
  assign slot_idx   = idx_q;

  // R7
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_busy |=> (fill == $past(fill)));

  // R3
  reject_keeps_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_rej |=> (full_err && fill == $past(fill)));

  // R6
  miss_keeps_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> (not_found && load_done && $stable(slot_idx) && $stable(slot_valid)));

  // R4
  hit_reports_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (slot_valid && !not_found && slot_idx == $past(hit_idx)));

  // R8
  save_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && load_req && !scan_busy) |=> !scan_busy);

endmodule

// File: tb/tb_cfgslot_mgr.sv
module tb_cfgslot_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 8;
  localparam int IDW        = 3;
  localparam int IXW        = $clog2(N);

  logic           clk;
  logic           rst_n;
  logic           save_req, load_req;
  logic [IDW-1:0] save_id, load_id;
  logic           busy, store_full, full_err, not_found, load_done, slot_valid;
  logic [IXW-1:0] slot_idx;

  int tests, fails;
  int ref_ids [N];
  int ref_cnt;
  int exp_slot, exp_valid;

  cfgslot_mgr #(.NUM_SLOTS(N), .ID_W(IDW)) dut (
    .clk(clk), .rst_n(rst_n),
    .save_req(save_req), .save_id(save_id),
    .load_req(load_req), .load_id(load_id),
    .busy(busy), .store_full(store_full), .full_err(full_err),
    .not_found(not_found), .load_done(load_done),
    .slot_valid(slot_valid), .slot_idx(slot_idx)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    save_req = 0; load_req = 0; save_id = 0; load_id = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    ref_cnt = 0; exp_slot = 0; exp_valid = 0;
  endtask

  task automatic do_save(input int id);
    save_req = 1; save_id = IDW'(id);
    @(negedge clk);
    save_req = 0;
    if (ref_cnt < N) begin
      ref_ids[ref_cnt] = id;
      ref_cnt++;
    end
  endtask

  task automatic do_load(input int id);
    int m, cyc, expc;
    m = -1;
    for (int i = ref_cnt - 1; i >= 0; i--)
      if (m < 0 && ref_ids[i] == id) m = i;
    load_req = 1; load_id = IDW'(id);
    @(negedge clk);
    load_req = 0;
    cyc = 0;
    while (busy && cyc < 40) begin
      cyc++;
      @(negedge clk);
    end
    expc = (m >= 0) ? ref_cnt - m : ref_cnt;
    chk(cyc == expc, (m >= 0) ? "R5 busy length on hit" : "R6 busy length on miss", cyc, expc);
    chk(load_done == 1'b1, "R4/R6 load_done pulse", int'(load_done), 1);
    chk(int'(not_found) == (m < 0), "R6 not_found", int'(not_found), int'(m < 0));
    if (m >= 0) begin exp_slot = m; exp_valid = 1; end
    chk(int'(slot_idx) == exp_slot, (m >= 0) ? "R4 slot_idx newest" : "R6 slot_idx unchanged",
        int'(slot_idx), exp_slot);
    chk(int'(slot_valid) == exp_valid, "R4/R6 slot_valid", int'(slot_valid), exp_valid);
    @(negedge clk);
    chk(load_done == 1'b0, "R4 load_done one cycle", int'(load_done), 0);
  endtask

  function automatic int pat_id(input int p, input int i);
    case (p)
      0:       return 5;
      1:       return i;
      2:       return 7 - i;
      3:       return (i * 3 + 1) % 8;
      default: return (i % 2) * 6;
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    tests = 0; fails = 0;
    do_reset();
    // R1
    chk(busy == 0,       "R1 busy",       int'(busy), 0);
    chk(store_full == 0, "R1 store_full", int'(store_full), 0);
    chk(full_err == 0,   "R1 full_err",   int'(full_err), 0);
    chk(not_found == 0,  "R1 not_found",  int'(not_found), 0);
    chk(slot_valid == 0, "R1 slot_valid", int'(slot_valid), 0);
    chk(load_done == 0,  "R1 load_done",  int'(load_done), 0);

    // R2 R4 R5 R6 R9: sweep of patterns and fill lengths
    for (int p = 0; p < 5; p++) begin
      for (int len = 0; len <= N; len++) begin
        do_reset();
        for (int i = 0; i < len; i++) do_save(pat_id(p, i));
        chk(int'(store_full) == (len == N), "R2/R9 store_full", int'(store_full), int'(len == N));
        if (len == N) begin
          // R3: extra save refused
          do_save((pat_id(p, 0) + 1) % 8);
          chk(full_err == 1, "R3 full_err on overflow", int'(full_err), 1);
          chk(store_full == 1, "R3 still full", int'(store_full), 1);
        end
        for (int id = 0; id < 8; id++) begin
          do_load(id);
          chk(full_err == 0, "R3 full_err cleared by accepted load", int'(full_err), 0);
        end
      end
    end

    // R7: requests during a running scan are ignored
    do_reset();
    for (int i = 0; i < 4; i++) do_save(i);
    load_req = 1; load_id = 3'd7;
    @(negedge clk);
    load_req = 1; load_id = 3'd2;
    save_req = 1; save_id = 3'd7;
    @(negedge clk);
    load_req = 0; save_req = 0;
    while (busy) @(negedge clk);
    chk(not_found == 1, "R7 running scan not restarted", int'(not_found), 1);
    do_load(7);
    chk(store_full == 0, "R7 no append while busy", int'(store_full), 0);

    // R8: simultaneous save and load while idle
    do_reset();
    do_save(4);
    save_req = 1; save_id = 3'd1; load_req = 1; load_id = 3'd4;
    @(negedge clk);
    save_req = 0; load_req = 0;
    chk(busy == 0, "R8 load dropped", int'(busy), 0);
    chk(load_done == 0, "R8 no lookup result", int'(load_done), 0);
    ref_ids[ref_cnt] = 1; ref_cnt++;
    do_load(1);
    chk(int'(slot_idx) == 1, "R8 save appended at slot 1", int'(slot_idx), 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule